// File: doc/BRIEF.md
# Direct-Mapped Branch Target Predictor

This block sits next to instruction fetch and predicts where the next fetch should go. It keeps a direct-mapped table. Each slot holds a valid flag, an address tag, a taken-branch target and a two-bit direction history. The fetch PC is looked up in the same cycle and gives a hit flag, a taken/not-taken guess and the predicted next PC.

When a branch resolves in execute, an update port writes the branch's tag and target into its slot and advances the history. The history is not a saturating counter. It is a direction bit plus a flag that records whether the most recent guess for that slot was right. The direction changes only after two wrong guesses in a row.

Top module: `bp_btb_predictor`

## Requirements
- R1: After reset every slot is empty: no fetch PC hits, `pred_taken` is 0 and `pred_next_pc` is the fetch PC plus 4.
- R2: PC bits [1:0] are ignored. With the default 12 index bits, PC bits [13:2] select the slot and bits [31:14] form the 18-bit tag. A fetch PC that differs from an updated PC only in bits [1:0] hits that entry.
- R3: A hit needs a slot that has been written and whose stored tag equals the fetch PC's tag. Two PCs that share an index but have different tags do not both hit.
- R4: On a miss, or on a hit whose direction bit is 0, `pred_taken` is 0 and `pred_next_pc` is the fetch PC plus 4.
- R5: On a hit whose direction bit is 1, `pred_taken` is 1 and `pred_next_pc` is the stored target with bits [1:0] equal to 0.
- R6: A newly filled slot starts with direction 0 (not taken) and correct-flag 1, and the resolved outcome is then applied to it. A first update that is taken therefore still predicts not taken.
- R7: An outcome that matches the direction bit leaves the direction unchanged and sets the correct-flag to 1.
- R8: An outcome that contradicts the direction bit while the correct-flag is 1 leaves the direction unchanged and clears the correct-flag.
- R9: An outcome that contradicts the direction bit while the correct-flag is 0 inverts the direction and sets the correct-flag to 1.
- R10: An update whose tag does not match the slot's stored tag replaces the tag and target and discards the old history before the outcome is applied. The old PC then misses.
- R11: Lookup is combinational and update is written at the clock edge. A lookup made in the same cycle as an update to the same slot sees the contents from before that update.
- R12: Every update rewrites the slot's stored target with the update's target address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; empties the table |
| fetch_pc | input | 32 | PC being fetched |
| pred_hit | output | 1 | Slot valid and tag matches |
| pred_taken | output | 1 | Hit and direction bit is 1 |
| pred_next_pc | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_target | input | 32 | Taken-branch target address of the resolved branch |

## Verification
The three prediction outputs depend only on the fetch PC and the table, with no register in between. They are due in the same cycle as the fetch PC. The bench drives the fetch PC on the falling edge and compares two nanoseconds later, which is well before the next rising edge.

An update takes effect at the next rising edge. A lookup that shares its cycle with an update is compared against the old contents. Every lookup after that is compared against the new contents.

Each history transition is checked by the direction it produces on the following lookups. The expected values follow from the update sequence written down in the bench.

// File: rtl/bp_pkg.sv
package bp_pkg;

    // Two-bit direction history per slot.
    typedef struct packed {
        logic dir;      // 1 = predict taken
        logic was_ok;   // most recent guess for this slot was correct
    } hist_t;

    localparam hist_t HIST_INIT = '{dir: 1'b0, was_ok: 1'b1};

    // Advance one slot's history with a resolved outcome.
    function automatic hist_t hist_step(input hist_t cur, input logic taken);
        hist_t nxt;
        nxt = cur;
        if (cur.dir == taken) begin
            nxt.was_ok = 1'b1;
        end else if (cur.was_ok) begin
            nxt.was_ok = 1'b0;
        end else begin
            nxt.dir    = ~cur.dir;
            nxt.was_ok = 1'b1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/bp_hist_table.sv
module bp_hist_table
    import bp_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic             rd_a_valid,
    output hist_t            rd_a_hist,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic             rd_b_valid,
    output hist_t            rd_b_hist,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  hist_t            wr_hist
);
    localparam int DEPTH = 1 << IDX_W;

    logic  valid_q [DEPTH];
    hist_t hist_q  [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                valid_q[i] <= 1'b0;
                hist_q[i]  <= HIST_INIT;
            end
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            hist_q[wr_idx]  <= wr_hist;
        end
    end

    assign rd_a_valid = valid_q[rd_a_idx];
    assign rd_a_hist  = hist_q[rd_a_idx];
    assign rd_b_valid = valid_q[rd_b_idx];
    assign rd_b_hist  = hist_q[rd_b_idx];
endmodule

// File: rtl/bp_target_store.sv
module bp_target_store #(
    parameter int IDX_W = 12,
    parameter int TAG_W = 18,
    parameter int TGT_W = 30
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [TAG_W-1:0] rd_a_tag,
    output logic [TGT_W-1:0] rd_a_tgt,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [TAG_W-1:0] rd_b_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [TGT_W-1:0] wr_tgt
);
    localparam int DEPTH = 1 << IDX_W;

    // Plain storage; the valid bits in the history table guard it.
    logic [TAG_W-1:0] tag_mem [DEPTH];
    logic [TGT_W-1:0] tgt_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
            tgt_mem[wr_idx] <= wr_tgt;
        end
    end

    assign rd_a_tag = tag_mem[rd_a_idx];
    assign rd_a_tgt = tgt_mem[rd_a_idx];
    assign rd_b_tag = tag_mem[rd_b_idx];
endmodule

// File: rtl/bp_lookup.sv
module bp_lookup
    import bp_pkg::*;
#(
    parameter int TAG_W = 18,
    parameter int TGT_W = 30
) (
    input  logic [31:0]      pc,
    input  logic [TAG_W-1:0] pc_tag,
    input  logic             slot_valid,
    input  logic [TAG_W-1:0] slot_tag,
    input  hist_t            slot_hist,
    input  logic [TGT_W-1:0] slot_tgt,
    output logic             hit,
    output logic             taken,
    output logic [31:0]      next_pc
);
    always_comb begin
        hit     = slot_valid && (slot_tag == pc_tag);
        taken   = hit && slot_hist.dir;
        next_pc = taken ? {slot_tgt, 2'b00} : (pc + 32'd4);
    end
endmodule

// File: rtl/bp_btb_predictor.sv
module bp_btb_predictor
    import bp_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] fetch_pc,
    output logic        pred_hit,
    output logic        pred_taken,
    output logic [31:0] pred_next_pc,
    input  logic        upd_valid,
    input  logic [31:0] upd_pc,
    input  logic        upd_taken,
    input  logic [31:0] upd_target
);
    localparam int WORD_W = 30;
    localparam int TAG_W  = WORD_W - IDX_W;
    localparam int TGT_W  = WORD_W;

    logic [IDX_W-1:0] f_idx, u_idx;
    logic [TAG_W-1:0] f_tag, u_tag;
    assign f_idx = fetch_pc[IDX_W+1:2];
    assign f_tag = fetch_pc[31:IDX_W+2];
    assign u_idx = upd_pc[IDX_W+1:2];
    assign u_tag = upd_pc[31:IDX_W+2];

    logic unused_low_bits;
    assign unused_low_bits = ^{upd_pc[1:0], upd_target[1:0]};

    logic             f_valid, u_valid;
    hist_t            f_hist, u_hist;
    logic [TAG_W-1:0] f_stag, u_stag;
    logic [TGT_W-1:0] f_stgt;
    hist_t            u_base, u_next;
    logic             u_match;

    bp_hist_table #(.IDX_W(IDX_W)) u_hist_tbl (
        .clk(clk), .rst(rst),
        .rd_a_idx(f_idx), .rd_a_valid(f_valid), .rd_a_hist(f_hist),
        .rd_b_idx(u_idx), .rd_b_valid(u_valid), .rd_b_hist(u_hist),
        .wr_en(upd_valid), .wr_idx(u_idx), .wr_hist(u_next)
    );

    bp_target_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(TGT_W)) u_tgt_store (
        .clk(clk),
        .rd_a_idx(f_idx), .rd_a_tag(f_stag), .rd_a_tgt(f_stgt),
        .rd_b_idx(u_idx), .rd_b_tag(u_stag),
        .wr_en(upd_valid), .wr_idx(u_idx), .wr_tag(u_tag),
        .wr_tgt(upd_target[31:2])
    );

    // A slot taken over by another branch starts from fresh history.
    always_comb begin
        u_match = u_valid && (u_stag == u_tag);
        u_base  = u_match ? u_hist : HIST_INIT;
        u_next  = hist_step(u_base, upd_taken);
    end

    bp_lookup #(.TAG_W(TAG_W), .TGT_W(TGT_W)) u_lookup (
        .pc(fetch_pc), .pc_tag(f_tag),
        .slot_valid(f_valid), .slot_tag(f_stag),
        .slot_hist(f_hist), .slot_tgt(f_stgt),
        .hit(pred_hit), .taken(pred_taken), .next_pc(pred_next_pc)
    );
endmodule

// File: rtl/bp_btb_checker.sv
module bp_btb_checker (
    input logic        clk,
    input logic        rst,
    input logic [31:0] fetch_pc,
    input logic        pred_hit,
    input logic        pred_taken,
    input logic [31:0] pred_next_pc,
    input logic        upd_valid,
    input logic [31:0] upd_pc
);
    // R1: the table is empty in the first cycle after reset.
    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !pred_hit);

    // R4: a taken guess is only possible on a hit.
    a_r4_taken_needs_hit: assert property (@(posedge clk) disable iff (rst)
        pred_taken |-> pred_hit);

    // R4: without a taken guess, fetch continues sequentially.
    a_r4_fallthrough: assert property (@(posedge clk) disable iff (rst)
        !pred_taken |-> (pred_next_pc == fetch_pc + 32'd4));

    // R5: a predicted target is word aligned.
    a_r5_target_aligned: assert property (@(posedge clk) disable iff (rst)
        pred_taken |-> (pred_next_pc[1:0] == 2'b00));

    // R2: a branch just written hits on the next cycle, whatever its low bits.
    a_r2_written_hits: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> ((fetch_pc[31:2] == $past(upd_pc[31:2])) |-> pred_hit));
endmodule

bind bp_btb_predictor bp_btb_checker u_chk (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
    .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_next_pc(pred_next_pc),
    .upd_valid(upd_valid), .upd_pc(upd_pc)
);

// File: tb/sim_bp_btb_predictor.sv
module sim_bp_btb_predictor;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_pc = '0;
    logic        pred_hit, pred_taken;
    logic [31:0] pred_next_pc;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;

    always #5 clk = ~clk;

    bp_btb_predictor u0 (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
        .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_next_pc(pred_next_pc),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target)
    );

    typedef struct {
        logic        hit;
        logic        tk;
        logic [31:0] nxt;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    event sample_ev;
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    // Monitor: compare each expected item shortly after its stimulus.
    initial begin
        forever begin
            @(sample_ev);
            #2;
            if (exp_q.size() != 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (pred_hit !== e.hit || pred_taken !== e.tk || pred_next_pc !== e.nxt) begin
                    n_fail++;
                    $display("FAIL %s: got hit=%0b taken=%0b next=%h, expected hit=%0b taken=%0b next=%h",
                             e.req, pred_hit, pred_taken, pred_next_pc, e.hit, e.tk, e.nxt);
                end
            end
        end
    end

    task automatic push_exp(input logic h, input logic t, input logic [31:0] n, input string r);
        exp_t e;
        e.hit = h; e.tk = t; e.nxt = n; e.req = r;
        exp_q.push_back(e);
        -> sample_ev;
    endtask

    task automatic look(input logic [31:0] pc, input logic h, input logic t,
                        input logic [31:0] n, input string r);
        @(negedge clk);
        fetch_pc = pc;
        push_exp(h, t, n, r);
        @(posedge clk);
    endtask

    task automatic upd(input logic [31:0] pc, input logic t, input logic [31:0] tgt);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_taken = t; upd_target = tgt;
        @(posedge clk);
        #1 upd_valid = 1'b0;
    endtask

    task automatic upd_and_look(input logic [31:0] pc, input logic t, input logic [31:0] tgt,
                                input logic h, input logic et, input logic [31:0] n,
                                input string r);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_taken = t; upd_target = tgt;
        fetch_pc = pc;
        push_exp(h, et, n, r);
        @(posedge clk);
        #1 upd_valid = 1'b0;
    endtask

    localparam logic [31:0] PC_A = 32'h0000_1000;
    localparam logic [31:0] PC_B = 32'h0000_5000; // same index as PC_A, other tag
    localparam logic [31:0] PC_C = 32'h0000_3000;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        look(PC_A, 0, 0, 32'h0000_1004, "R1 empty after reset");
        look(32'h0000_2468, 0, 0, 32'h0000_246C, "R4 miss falls through");

        upd(PC_A, 1, 32'h0000_2000);            // fresh: dir0 ok1 -> wrong -> dir0 ok0
        look(PC_A, 1, 0, 32'h0000_1004, "R6 first taken still not taken");
        look(32'h0000_1003, 1, 0, 32'h0000_1007, "R2 low bits ignored");

        upd(PC_A, 1, 32'h0000_2000);            // second wrong -> dir1 ok1
        look(PC_A, 1, 1, 32'h0000_2000, "R9 flip after two wrong");
        look(PC_A, 1, 1, 32'h0000_2000, "R5 taken gives target");

        upd(PC_A, 0, 32'h0000_2000);            // wrong with ok1 -> dir1 ok0
        look(PC_A, 1, 1, 32'h0000_2000, "R8 single wrong keeps direction");

        upd(PC_A, 1, 32'h0000_2000);            // correct -> dir1 ok1
        look(PC_A, 1, 1, 32'h0000_2000, "R7 correct keeps direction");
        upd(PC_A, 0, 32'h0000_2000);            // wrong with ok1 -> dir1 ok0
        look(PC_A, 1, 1, 32'h0000_2000, "R7 correct restored flag");
        upd(PC_A, 0, 32'h0000_2000);            // wrong with ok0 -> dir0 ok1
        look(PC_A, 1, 0, 32'h0000_1004, "R9 flip to not taken");
        upd(PC_A, 1, 32'h0000_2000);            // wrong ok1 -> dir0 ok0
        upd(PC_A, 1, 32'h0000_2000);            // flip -> dir1 ok1

        look(PC_B, 0, 0, 32'h0000_5004, "R3 alias tag misses");
        upd(PC_B, 0, 32'h0000_7000);            // replace: dir0 ok1, correct
        look(PC_B, 1, 0, 32'h0000_5004, "R10 history reinitialised");
        look(PC_A, 0, 0, 32'h0000_1004, "R10 old tag misses");

        upd(PC_B, 1, 32'h0000_7000);            // dir0 ok0
        upd(PC_B, 1, 32'h0000_7000);            // dir1 ok1
        look(PC_B, 1, 1, 32'h0000_7000, "R10 new target used");
        upd(PC_B, 1, 32'h0000_7400);            // correct, new target
        look(PC_B, 1, 1, 32'h0000_7400, "R12 target rewritten");

        upd_and_look(PC_B, 1, 32'h0000_7800, 1, 1, 32'h0000_7400, "R11 same cycle sees old target");
        look(PC_B, 1, 1, 32'h0000_7800, "R11 update visible next cycle");
        upd_and_look(PC_C, 1, 32'h0000_9000, 0, 0, 32'h0000_3004, "R11 same cycle fill still misses");
        look(PC_C, 1, 0, 32'h0000_3004, "R11 fill visible next cycle");

        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        look(PC_B, 0, 0, 32'h0000_5004, "R1 reset empties table");
        look(PC_C, 0, 0, 32'h0000_3004, "R1 reset empties table");

        repeat (2) @(posedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got running, expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule